// File: doc/BRIEF.md
# Key Autorepeat Code Generator

This block sits between a key-matrix debouncer and the key-event queue of a keypad controller. While at least one key stays held, it waits a programmable number of debounce cycles after the most recent recorded key event. It then asks the queue to store one shared repeat code. After that it keeps asking again at a programmable interval until the next key event is recorded.

All timing is counted in debounce ticks. A tick is a single-cycle pulse from the debouncer. Every recorded press or release restarts the whole sequence from the beginning. The block never tracks which key or how many keys are held: one code stands for any held set. An 8-bit configuration word supplies the controls:

- bit 7: enable.
- bits 6:4: repeat interval.
- bits 3:0: initial delay.

Top module: `autorep_gen`

## Requirements
- R1: When cfg bit 7 is 0 the block never raises `push`, whatever the other inputs do.
- R2: With the block enabled and a key held, the first `push` follows the tick that ends a delay of (cfg[3:0]+1)*8 ticks counted after the last key event (8 to 128 ticks).
- R3: After each push the next one follows the tick that ends an interval of (cfg[6:4]+1)*4 ticks (4 to 32 ticks).
- R4: A `key_evt` strobe, press or release, restarts the full initial delay if a key is still held. When a strobe and a tick fall in the same cycle, the strobe wins and that tick is not counted.
- R5: Whenever `push` is high, `push_code` carries 0x7E. Otherwise it is 0x00.
- R6: `push` is a one-cycle pulse, high in the clock cycle right after the edge that samples the completing tick. There is at most one push per tick, however many keys are held.
- R7: Repeat pushes continue at the set interval for as long as no further key event occurs.
- R8: While `held` is low or the block is disabled, the counting returns to idle. Counting resumed later without an event still needs the full initial delay.
- R9: After synchronous reset, `push` is low, `push_code` is 0x00 and the count is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per debounce cycle |
| held | input | 1 | High while any debounced key is down |
| key_evt | input | 1 | Strobe: a press or release was recorded |
| cfg | input | 8 | Enable [7], interval [6:4], delay [3:0] |
| push | output | 1 | Request to store the repeat code |
| push_code | output | 8 | Code to store, 0x7E during a push |

## Verification
The push that a completing tick causes is registered once, so it is due in the cycle that starts at the clock edge sampling that tick. The bench drives each input at a falling edge and samples shortly after the following rising edge. Each sample therefore belongs to exactly the tick or strobe just applied. Delays and intervals are measured by counting ticks until the first sampled push and comparing the count with the value computed from the configuration word. This holds for both sparse and back-to-back tick patterns.

// File: rtl/autorep_pkg.sv
`timescale 1ns/1ps
package autorep_pkg;
  typedef enum logic {PH_WAIT = 1'b0, PH_RPT = 1'b1} ar_phase_t;
  localparam logic [7:0] REPEAT_CODE = 8'h7E;
endpackage

// File: rtl/ar_cfg_decode.sv
`timescale 1ns/1ps
module ar_cfg_decode #(
  parameter int DLY_BITS  = 4,
  parameter int RATE_BITS = 3,
  parameter int DLY_STEP  = 8,
  parameter int RATE_STEP = 4,
  parameter int CFG_W     = DLY_BITS + RATE_BITS + 1,
  parameter int CNT_W     = $clog2(DLY_STEP * (2 ** DLY_BITS)) + 1
) (
  input  logic [CFG_W-1:0] cfg,
  output logic             en,
  output logic [CNT_W-1:0] dly_tgt,
  output logic [CNT_W-1:0] rate_tgt
);
  localparam int EN_POS = DLY_BITS + RATE_BITS;

  always_comb begin
    en       = cfg[EN_POS];
    dly_tgt  = CNT_W'((int'(cfg[DLY_BITS-1:0]) + 1) * DLY_STEP);
    rate_tgt = CNT_W'((int'(cfg[DLY_BITS +: RATE_BITS]) + 1) * RATE_STEP);
  end
endmodule

// File: rtl/ar_interval_counter.sv
`timescale 1ns/1ps
module ar_interval_counter
  import autorep_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int CNT_MAX = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] dly_tgt,
  input  logic [CNT_W-1:0] rate_tgt,
  output logic             fire
);
  ar_phase_t        phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_tgt;

  always_comb begin
    cur_tgt = (phase == PH_RPT) ? rate_tgt : dly_tgt;
    fire    = run && !restart && tick && (cnt >= cur_tgt - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt   <= '0;
      phase <= PH_WAIT;
    end else if (tick) begin
      if (fire) begin
        cnt   <= '0;
        phase <= PH_RPT;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < CNT_MAX);  // R2
  AST_RPT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(phase == PH_RPT) |-> $past(tick) && $past(run));  // R3
  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> (cnt == '0) && (phase == PH_WAIT));  // R8
endmodule

// File: rtl/autorep_gen.sv
`timescale 1ns/1ps
module autorep_gen
  import autorep_pkg::*;
#(
  parameter int DLY_BITS  = 4,
  parameter int RATE_BITS = 3,
  parameter int DLY_STEP  = 8,
  parameter int RATE_STEP = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       held,
  input  logic       key_evt,
  input  logic [7:0] cfg,
  output logic       push,
  output logic [7:0] push_code
);
  localparam int CFG_W   = DLY_BITS + RATE_BITS + 1;
  localparam int CNT_MAX = DLY_STEP * (2 ** DLY_BITS);
  localparam int CNT_W   = $clog2(CNT_MAX) + 1;

  logic             en;
  logic [CNT_W-1:0] dly_tgt;
  logic [CNT_W-1:0] rate_tgt;
  logic             fire;

  ar_cfg_decode #(
    .DLY_BITS(DLY_BITS), .RATE_BITS(RATE_BITS),
    .DLY_STEP(DLY_STEP), .RATE_STEP(RATE_STEP),
    .CFG_W(CFG_W), .CNT_W(CNT_W)
  ) u_dec (
    .cfg(cfg[CFG_W-1:0]), .en(en), .dly_tgt(dly_tgt), .rate_tgt(rate_tgt)
  );

  ar_interval_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_cnt (
    .clk(clk), .rst(rst), .run(en && held), .restart(key_evt),
    .tick(tick), .dly_tgt(dly_tgt), .rate_tgt(rate_tgt), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      push      <= 1'b0;
      push_code <= 8'h00;
    end else begin
      push      <= fire;
      push_code <= fire ? REPEAT_CODE : 8'h00;
    end
  end

  AST_PUSH_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(cfg[7]) && $past(held));  // R1
  AST_PUSH_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(tick));  // R6
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    push |=> !push);  // R6
  AST_EVT_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (rst)
    push |-> !$past(key_evt));  // R4
endmodule

// File: tb/tb_autorep_gen.sv
`timescale 1ns/1ps
module tb_autorep_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       held = 1'b0;
  logic       key_evt = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       push;
  logic [7:0] push_code;

  int checks = 0;
  int errors = 0;
  localparam int CAP = 200;

  always #10 clk = ~clk;

  autorep_gen dut (
    .clk(clk), .rst(rst), .tick(tick), .held(held), .key_evt(key_evt),
    .cfg(cfg), .push(push), .push_code(push_code)
  );

  // {cfg, expected delay ticks, expected interval ticks}
  localparam int NV = 5;
  localparam logic [23:0] VEC [NV] = '{
    {8'h80, 8'd8,   8'd4},
    {8'h8F, 8'd128, 8'd4},
    {8'hF0, 8'd8,   8'd32},
    {8'hA3, 8'd32,  8'd12},
    {8'hD6, 8'd56,  8'd24}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic e);
    @(negedge clk);
    tick = t;
    key_evt = e;
    @(posedge clk);
    #3;
    tick = 1'b0;
    key_evt = 1'b0;
  endtask

  // count ticks until a push; gap=1 inserts an idle cycle after each tick
  task automatic ticks_to_push(input bit gap, output int n, output logic [7:0] code);
    n = 0;
    code = 8'h00;
    while (n <= CAP) begin
      cyc(1'b1, 1'b0);
      n++;
      if (push) begin
        code = push_code;
        break;
      end
      if (gap) cyc(1'b0, 1'b0);
    end
    if (gap) cyc(1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] code;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(push == 1'b0, "R9 push after reset", int'(push), 0);
    chk(push_code == 8'h00, "R9 code after reset", int'(push_code), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      cfg = VEC[v][23:16];
      held = 1'b1;
      cyc(1'b0, 1'b1);
      ticks_to_push(1'b1, n, code);
      chk(n == int'(VEC[v][15:8]), "R2 initial delay", n, int'(VEC[v][15:8]));
      chk(code == 8'h7E, "R5 repeat code", int'(code), 8'h7E);
      ticks_to_push(1'b1, n, code);
      chk(n == int'(VEC[v][7:0]), "R3 repeat interval", n, int'(VEC[v][7:0]));
      ticks_to_push(1'b1, n, code);
      chk(n == int'(VEC[v][7:0]), "R7 repeats continue", n, int'(VEC[v][7:0]));
    end

    // R1: disabled, all other fields set
    cfg = 8'h7F; held = 1'b1;
    cyc(1'b0, 1'b1);
    ticks_to_push(1'b0, n, code);
    chk(n > CAP, "R1 disabled no push", n, CAP + 1);

    // R4: event mid-delay restarts the delay
    cfg = 8'h80;
    cyc(1'b0, 1'b1);
    repeat (5) cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b1);
    ticks_to_push(1'b1, n, code);
    chk(n == 8, "R4 event restarts delay", n, 8);
    // release event with a key still held, after repeats began
    ticks_to_push(1'b1, n, code);
    cyc(1'b0, 1'b1);
    ticks_to_push(1'b1, n, code);
    chk(n == 8, "R4 release restarts delay", n, 8);

    // R4: event and tick in the same cycle, event wins
    cyc(1'b0, 1'b1);
    repeat (7) cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b1);
    chk(push == 1'b0, "R4 event beats tick", int'(push), 0);
    ticks_to_push(1'b1, n, code);
    chk(n == 8, "R4 tick with event not counted", n, 8);

    // R8: held drops mid-delay; no push while released; full delay after
    cyc(1'b0, 1'b1);
    repeat (5) cyc(1'b1, 1'b0);
    held = 1'b0;
    ticks_to_push(1'b0, n, code);
    chk(n > CAP, "R8 no push while not held", n, CAP + 1);
    held = 1'b1;
    ticks_to_push(1'b1, n, code);
    chk(n == 8, "R8 resume needs full delay", n, 8);

    // R8: disabling mid-delay also clears the count
    cyc(1'b0, 1'b1);
    repeat (6) cyc(1'b1, 1'b0);
    cfg = 8'h00;
    cyc(1'b1, 1'b0);
    cfg = 8'h80;
    ticks_to_push(1'b1, n, code);
    chk(n == 8, "R8 disable clears count", n, 8);

    // R6: back-to-back ticks, push is a single-cycle pulse
    cyc(1'b0, 1'b1);
    ticks_to_push(1'b0, n, code);
    chk(n == 8, "R6 delay with continuous ticks", n, 8);
    cyc(1'b1, 1'b0);
    chk(push == 1'b0, "R6 push lasts one cycle", int'(push), 0);
    chk(push_code == 8'h00, "R5 code idle without push", int'(push_code), 0);
    ticks_to_push(1'b0, n, code);
    chk(n == 3, "R6 interval continuous ticks", n, 3);

    // R9: reset mid-delay returns to idle
    cyc(1'b0, 1'b1);
    repeat (6) cyc(1'b1, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ticks_to_push(1'b1, n, code);
    chk(n == 8, "R9 reset clears count", n, 8);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule